// File: doc/BRIEF.md
# Serially Shared Memory Self-Test Wrapper

This block runs a built-in march test over a group of single-port, word-access memories that all share one data width and one clock. Instead of giving every memory its own generators and checker, the wrapper treats the group as one deep memory. The address counter is widened by `SELW` upper select bits above the `AW`-bit word address. The select bits pick the single memory whose chip enable is raised. One data generator and one response checker, each `DW` bits wide, serve every memory in turn.

A test controller pulses `start`. The wrapper applies an eight-operation march to every word of the combined space, once for each of `NBG` data backgrounds, and then raises `done`. A sticky `fail` flag records any read mismatch, along with the select value and word address of the first one. Only one memory is enabled at a time, so peak test power is that of the hungriest memory in the group. During scan test, `scan_en` quiets every memory strobe and freezes the engine. A bank of bypass flops then samples the memories' read buses so that scan can observe them.

Top module: `mbist_serial_wrap`

## Requirements
- R1: After reset, `done` and `fail` are 0, every bit of `mem_ce` is 0, and `mem_we` is 0.
- R2: A `start` seen while idle or finished begins a run, with one memory operation per clock. For each background, the run applies these five elements in order: ascending write-0; ascending read-0 then write-1; descending read-1 then write-0; ascending read-0 then write-1; descending read-1. That is 8 x 2^SELW x 2^AW operations per background.
- R3: The combined address is {select, word}. Ascending elements run it from 0 to its maximum and descending elements run it from its maximum to 0, stepping by one across memory boundaries.
- R4: During an operation, exactly the `mem_ce` bit whose index equals the select bits is 1. At no time is more than one bit of `mem_ce` set.
- R5: Backgrounds are applied in index order 0, 1, 2. For a "0" operation, background 0 is all zeros. Background 1 sets bit i to 1 when i is even, then XORs every bit with bit 0 of the combined address. Background 2 is the bitwise inverse of background 1. A "1" operation uses the inverse of the "0" value. Reads expect exactly the value the operation names.
- R6: The selected memory returns read data on the clock after the read. On a mismatch, `fail` rises one clock later and stays set. `fail_sel` and `fail_addr` hold the select and word address of the first mismatch of the run and are not changed by later mismatches.
- R7: `done` rises two clocks after the last operation of the run is presented. It stays high until the next accepted `start`, and that `start` also clears `fail`.
- R8: While `scan_en` is 1, every `mem_ce` bit and `mem_we` are 0 and the run does not advance. When `scan_en` returns to 0, the run resumes at the same operation.
- R9: On each clock where `scan_en` is 1, `byp_obs` loads `mem_rdata`. On other clocks it holds its value.
- R10: A `start` pulse during a run is ignored, and the operation sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock shared by all grouped memories |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run |
| scan_en | input | 1 | Scan mode: quiet memories, hold engine, capture bypass flops |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_sel | output | SELW | Memory index of the first mismatch |
| fail_addr | output | AW | Word address of the first mismatch |
| mem_ce | output | 2**SELW | Per-memory chip enable |
| mem_addr | output | AW | Word address to all memories |
| mem_wdata | output | DW | Write data to all memories |
| mem_we | output | 1 | Write enable (1 = write) |
| mem_rdata | input | 2**SELW*DW | Read buses, memory i at bits [i*DW +: DW] |
| byp_obs | output | 2**SELW*DW | Bypass flops observing the read buses |

## Verification
The bench drives the full three-background march and compares every presented operation against its own list. A counter that failed to borrow from the select bits in a descending element would break the contiguous address check at each memory boundary. Faults in the bench memories show whether mismatches are caught: a stuck-at-1 bit is caught on the first ascending read. With a second stuck bit that only a later descending read exposes, a checker that let a later mismatch overwrite the captured location would report the wrong memory and word. A scan-mode stall and a `start` pulse inside a run test the freeze and the ignore rules: an engine that advanced, restarted or left an enable up would fall out of step with the expected list. A final clean run after a failing one confirms that `fail` is cleared.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } wrap_state_e;

  localparam logic [2:0] LAST_ELEM = 3'd4;

  // Elements 2 and 4 walk the combined address downward.
  function automatic logic elem_desc(input logic [2:0] e);
    return (e == 3'd2) || (e == 3'd4);
  endfunction

  // Elements 1..3 hold a read followed by a write.
  function automatic logic elem_pair(input logic [2:0] e);
    return (e == 3'd1) || (e == 3'd2) || (e == 3'd3);
  endfunction

  function automatic logic op_write(input logic [2:0] e, input logic op);
    return (e == 3'd0) || op;
  endfunction

  // 1 when the operation uses the inverted background.
  function automatic logic op_inv(input logic [2:0] e, input logic op);
    case (e)
      3'd0:    return 1'b0;
      3'd1:    return op;
      3'd2:    return ~op;
      3'd3:    return op;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          step,
  input  logic          down,
  output logic [TW-1:0] caddr,
  output logic          at_end
);

  localparam logic [TW-1:0] TOP = {TW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     caddr <= '0;
    else if (load)  caddr <= load_val;
    else if (step)  caddr <= down ? caddr - 1'b1 : caddr + 1'b1;
  end

  assign at_end = down ? (caddr == '0) : (caddr == TOP);

  // R3: one step moves the combined address by exactly one word
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ((caddr == $past(caddr) + 1'b1) || (caddr == $past(caddr) - 1'b1)));

endmodule

// File: rtl/mbist_resp_chk.sv
module mbist_resp_chk #(
  parameter int SELW = 2,
  parameter int AW   = 5,
  parameter int DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     chk_vld,
  input  logic [DW-1:0]            chk_exp,
  input  logic [SELW-1:0]          chk_sel,
  input  logic [AW-1:0]            chk_addr,
  input  logic [(2**SELW)*DW-1:0]  rdata_flat,
  output logic                     fail,
  output logic [SELW-1:0]          fail_sel,
  output logic [AW-1:0]            fail_addr
);

  logic [DW-1:0] rd_word;
  logic          mismatch;

  assign rd_word  = rdata_flat[chk_sel*DW +: DW];
  assign mismatch = chk_vld && (rd_word != chk_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_sel  <= '0;
      fail_addr <= '0;
    end else if (clr) begin
      fail      <= 1'b0;
      fail_sel  <= '0;
      fail_addr <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_sel  <= chk_sel;
      fail_addr <= chk_addr;
    end
  end

  // R6: fail stays set until a new run clears it
  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> fail);

  // R6: the first captured location is never overwritten
  p_first_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> ($stable(fail_sel) && $stable(fail_addr)));

endmodule

// File: rtl/mbist_bypass.sv
module mbist_bypass #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dout <= '0;
    else if (cap) dout <= din;
  end

  // R9: outside scan the bypass flops keep their value
  p_byp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(dout));

endmodule

// File: rtl/mbist_serial_wrap.sv
module mbist_serial_wrap
  import mbist_pkg::*;
#(
  parameter int SELW = 2,
  parameter int AW   = 5,
  parameter int DW   = 8,
  parameter int NBG  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     scan_en,
  output logic                     done,
  output logic                     fail,
  output logic [SELW-1:0]          fail_sel,
  output logic [AW-1:0]            fail_addr,
  output logic [(2**SELW)-1:0]     mem_ce,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  output logic                     mem_we,
  input  logic [(2**SELW)*DW-1:0]  mem_rdata,
  output logic [(2**SELW)*DW-1:0]  byp_obs
);

  localparam int NMEM = 2 ** SELW;
  localparam int TW   = SELW + AW;
  localparam int BGW  = (NBG > 1) ? $clog2(NBG) : 1;
  localparam logic [BGW-1:0] BG_LAST = BGW'(NBG - 1);

  // Background word for a "0" operation.
  function automatic logic [DW-1:0] bg_word(input logic [BGW-1:0] b, input logic a0);
    logic [DW-1:0] chk;
    for (int i = 0; i < DW; i++) chk[i] = ((i % 2) == 0) ^ a0;
    if (b == '0)             return '0;
    else if (b[0])           return chk;
    else                     return ~chk;
  endfunction

  wrap_state_e     st, st_nx;
  logic [2:0]      elem;
  logic            op;
  logic [BGW-1:0]  bg;
  logic [TW-1:0]   caddr;
  logic            at_end;

  // named internal events
  logic            start_acc, act, last_op, elem_end, finish;
  logic            cur_we, cur_inv, cur_down;
  logic [2:0]      elem_nx;
  logic [SELW-1:0] sel;
  logic [DW-1:0]   cur_word;
  logic            ag_load, ag_step;
  logic [TW-1:0]   ag_val;

  assign start_acc = ((st == ST_IDLE) || (st == ST_DONE)) && start;
  assign act       = (st == ST_RUN) && !scan_en;
  assign cur_down  = elem_desc(elem);
  assign last_op   = op || !elem_pair(elem);
  assign elem_end  = act && last_op && at_end;
  assign finish    = elem_end && (elem == LAST_ELEM) && (bg == BG_LAST);
  assign elem_nx   = (elem == LAST_ELEM) ? 3'd0 : elem + 3'd1;
  assign cur_we    = op_write(elem, op);
  assign cur_inv   = op_inv(elem, op);
  assign sel       = caddr[TW-1:AW];
  assign cur_word  = bg_word(bg, caddr[0]) ^ {DW{cur_inv}};

  assign ag_load = start_acc || (elem_end && !finish);
  assign ag_val  = (!start_acc && elem_desc(elem_nx)) ? {TW{1'b1}} : '0;
  assign ag_step = act && last_op && !at_end;

  mbist_addr_gen #(.TW(TW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ag_load), .load_val(ag_val),
    .step(ag_step), .down(cur_down), .caddr(caddr), .at_end(at_end)
  );

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (start) st_nx = ST_RUN;
      ST_RUN:   if (finish) st_nx = ST_DRAIN;
      ST_DRAIN: st_nx = ST_DONE;
      default:  if (start) st_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      elem <= '0;
      op   <= 1'b0;
      bg   <= '0;
    end else begin
      st <= st_nx;
      if (start_acc) begin
        elem <= '0;
        op   <= 1'b0;
        bg   <= '0;
      end else if (act) begin
        if (!last_op) begin
          op <= 1'b1;
        end else begin
          op <= 1'b0;
          if (at_end && !finish) begin
            elem <= elem_nx;
            if (elem == LAST_ELEM) bg <= bg + 1'b1;
          end
        end
      end
    end
  end

  // read issue pipeline for the shared checker
  logic            rd_vld_q;
  logic [DW-1:0]   exp_q;
  logic [SELW-1:0] sel_q;
  logic [AW-1:0]   addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      exp_q    <= '0;
      sel_q    <= '0;
      addr_q   <= '0;
    end else begin
      rd_vld_q <= act && !cur_we;
      exp_q    <= cur_word;
      sel_q    <= sel;
      addr_q   <= caddr[AW-1:0];
    end
  end

  for (genvar gi = 0; gi < NMEM; gi++) begin : g_ce
    assign mem_ce[gi] = act && (sel == SELW'(gi));
  end

  assign mem_addr  = caddr[AW-1:0];
  assign mem_wdata = cur_word;
  assign mem_we    = act && cur_we;
  assign done      = (st == ST_DONE);

  mbist_resp_chk #(.SELW(SELW), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .chk_vld(rd_vld_q),
    .chk_exp(exp_q), .chk_sel(sel_q), .chk_addr(addr_q),
    .rdata_flat(mem_rdata), .fail(fail), .fail_sel(fail_sel),
    .fail_addr(fail_addr)
  );

  mbist_bypass #(.W(NMEM * DW)) u_byp (
    .clk(clk), .rst_n(rst_n), .cap(scan_en), .din(mem_rdata), .dout(byp_obs)
  );

  // R4: never more than one memory enabled
  p_ce_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_ce));

  // R4: a write always lands in some enabled memory
  p_we_has_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_ce != '0));

  // R8: scan mode freezes the march position
  p_scan_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && (st == ST_RUN)) |=> ($stable(caddr) && $stable(elem) && $stable(op)));

  // R7: done holds until a new start
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R10: a start inside a run does not rewind the engine
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RUN) && start && !act) |=> ((st == ST_RUN) && $stable(caddr)));

endmodule

// File: tb/sim_mbist_serial_wrap.sv
module sim_mbist_serial_wrap;

  localparam int SELW  = 2;
  localparam int AW    = 5;
  localparam int DW    = 8;
  localparam int NBG   = 3;
  localparam int NMEM  = 4;
  localparam int WORDS = 32;
  localparam int TOTW  = NMEM * WORDS;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, scan_en = 1'b0;
  logic done, fail;
  logic [SELW-1:0]      fail_sel;
  logic [AW-1:0]        fail_addr;
  logic [NMEM-1:0]      mem_ce;
  logic [AW-1:0]        mem_addr;
  logic [DW-1:0]        mem_wdata;
  logic                 mem_we;
  logic [NMEM*DW-1:0]   mem_rdata;
  logic [NMEM*DW-1:0]   byp_obs;

  always #4 clk = ~clk;

  mbist_serial_wrap #(.SELW(SELW), .AW(AW), .DW(DW), .NBG(NBG)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en),
    .done(done), .fail(fail), .fail_sel(fail_sel), .fail_addr(fail_addr),
    .mem_ce(mem_ce), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .byp_obs(byp_obs)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;

  // fault slots: stuck bit applied on write
  bit   f_on  [2];
  int   f_mem [2];
  int   f_adr [2];
  int   f_bit [2];
  logic f_val [2];

  function automatic logic [DW-1:0] faulty(int m, int a, logic [DW-1:0] d);
    logic [DW-1:0] r = d;
    for (int s = 0; s < 2; s++)
      if (f_on[s] && f_mem[s] == m && f_adr[s] == a) r[f_bit[s]] = f_val[s];
    return r;
  endfunction

  // memory models: synchronous single-port
  logic [DW-1:0]      marr [NMEM][WORDS];
  logic [NMEM*DW-1:0] rdq = '0;
  assign mem_rdata = rdq;

  always @(posedge clk) begin
    for (int m = 0; m < NMEM; m++) begin
      if (mem_ce[m]) begin
        if (mem_we) marr[m][mem_addr] <= faulty(m, int'(mem_addr), mem_wdata);
        else        rdq[m*DW +: DW]   <= marr[m][mem_addr];
      end
    end
  end

  // reference operation list
  typedef struct packed {
    logic          we;
    logic [6:0]    ca;
    logic [DW-1:0] d;
  } op_t;
  op_t exp_q[$];

  int e_n  [5] = '{1, 2, 2, 2, 1};
  bit e_dn [5] = '{0, 0, 1, 0, 1};
  bit e_w0 [5] = '{1, 0, 0, 0, 0};   // first op writes
  bit e_v0 [5] = '{0, 0, 1, 0, 1};   // first op value
  bit e_v1 [5] = '{0, 1, 0, 1, 0};   // second op value (write)

  function automatic logic [DW-1:0] pat(int b, int ca, bit v);
    logic [DW-1:0] w = '0;
    if (b != 0) for (int i = 0; i < DW; i++) w[i] = ((i % 2) == 0) ^ (ca % 2 == 1);
    if (b == 2) w = ~w;
    return v ? ~w : w;
  endfunction

  task automatic build_ops();
    op_t o;
    exp_q.delete();
    for (int b = 0; b < NBG; b++)
      for (int e = 0; e < 5; e++)
        for (int j = 0; j < TOTW; j++) begin
          int ca = e_dn[e] ? (TOTW - 1 - j) : j;
          o.ca = 7'(ca); o.we = e_w0[e]; o.d = pat(b, ca, e_v0[e]);
          exp_q.push_back(o);
          if (e_n[e] == 2) begin
            o.we = 1'b1; o.d = pat(b, ca, e_v1[e]);
            exp_q.push_back(o);
          end
        end
  endtask

  bit pf; int psel, padr;
  task automatic predict();
    logic [DW-1:0] ref_m [TOTW];
    pf = 0; psel = 0; padr = 0;
    foreach (exp_q[i]) begin
      int ca = int'(exp_q[i].ca);
      if (exp_q[i].we) ref_m[ca] = faulty(ca / WORDS, ca % WORDS, exp_q[i].d);
      else if (!pf && ref_m[ca] != exp_q[i].d) begin
        pf = 1; psel = ca / WORDS; padr = ca % WORDS;
      end
    end
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  task automatic run(int stall_at, int stall_len, int poke_at);
    int k = 0, cyc = 0;
    bit prev_scan = 0;
    logic [NMEM*DW-1:0] prev_rd = '0, byp_ref;
    build_ops();
    predict();
    byp_ref = byp_obs;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    while (k < exp_q.size()) begin
      op_t o;
      scan_en = (cyc >= stall_at && cyc < stall_at + stall_len);
      start   = (cyc == poke_at);
      #1;
      if (prev_scan) begin
        byp_ref = prev_rd;
        chk(byp_obs == prev_rd, "R9", "bypass capture", byp_obs, prev_rd);
      end else if (cyc > 0) begin
        chk(byp_obs == byp_ref, "R9", "bypass hold", byp_obs, byp_ref);
      end
      if (scan_en) begin
        chk(mem_ce == 0 && !mem_we, "R8", "scan quiet ce", mem_ce, 0);
      end else begin
        o = exp_q[k];
        chk(mem_ce == NMEM'(1 << (o.ca / WORDS)), "R4", "chip enable", mem_ce, 1 << (o.ca / WORDS));
        chk(mem_addr == AW'(o.ca % WORDS), "R3", "word address", mem_addr, o.ca % WORDS);
        chk(mem_we == o.we, "R2", "op kind", mem_we, o.we);
        if (o.we) chk(mem_wdata == o.d, "R5", "write data", mem_wdata, o.d);
        k++;
      end
      prev_scan = scan_en;
      prev_rd   = mem_rdata;
      cyc++;
      @(negedge clk);
    end
    scan_en = 1'b0; start = 1'b0;
    #1;
    chk(!done && mem_ce == 0, "R7", "drain cycle done", done, 0);
    @(negedge clk); #1;
    chk(done, "R7", "done raised", done, 1);
    chk(fail == pf, "R6", "fail flag", fail, pf);
    if (pf) begin
      chk(int'(fail_sel) == psel, "R6", "first fail select", fail_sel, psel);
      chk(int'(fail_addr) == padr, "R6", "first fail word", fail_addr, padr);
    end
    repeat (3) @(negedge clk);
    #1;
    chk(done && fail == pf, "R7", "done and fail held", {done, fail}, {1'b1, pf});
  endtask

  initial begin
    for (int m = 0; m < NMEM; m++) for (int a = 0; a < WORDS; a++) marr[m][a] = '0;
    for (int s = 0; s < 2; s++) begin f_on[s] = 0; f_mem[s] = 0; f_adr[s] = 0; f_bit[s] = 0; f_val[s] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !fail, "R1", "reset flags", {done, fail}, 0);
    chk(mem_ce == 0 && !mem_we, "R1", "reset strobes", {mem_ce, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!done && mem_ce == 0, "R1", "idle after reset", {done, mem_ce}, 0);

    // clean pass over all backgrounds (R2, R3, R5)
    run(-1, 0, -1);
    // scan stall mid-run and a stray start (R8, R9, R10)
    run(500, 6, 900);
    // one stuck-at-1 bit in memory 2 word 7 (R6)
    f_on[0] = 1; f_mem[0] = 2; f_adr[0] = 7; f_bit[0] = 0; f_val[0] = 1'b1;
    run(-1, 0, -1);
    // two faults: the one seen first in time must be the one captured (R6)
    f_on[0] = 1; f_mem[0] = 1; f_adr[0] = 3; f_bit[0] = 5; f_val[0] = 1'b0;
    f_on[1] = 1; f_mem[1] = 3; f_adr[1] = 0; f_bit[1] = 2; f_val[1] = 1'b1;
    run(-1, 0, -1);
    // clean run after a failure: start clears fail (R7)
    f_on[0] = 0; f_on[1] = 0;
    run(2000, 3, -1);

    summary();
    $finish;
  end

endmodule